// File: doc/BRIEF.md
# Matrix switch-input polling sequencer

This block schedules the sampling of twelve switch inputs, numbered 0 to 11 at its ports. Inputs 0 to 5 form the sink side and inputs 6 to 11 the source side. A two-bit mode picks one of three square matrix sizes, or no matrix at all. When a matrix is in use, every pairing of a sink-side input with a source-side input inside the square is polled as one combination. The sink-side inputs and source-side inputs outside the square are polled on their own afterwards.

For each slot the block raises the enable of the input, or of the pair, for a programmed number of cycles. It then holds the enable for one more cycle and marks that cycle with a strobe, and the external comparator result is captured at the end of the strobe cycle. At the end of every pass the captured bits are moved into the status outputs, and these become the reference for the next pass. An active-low interrupt and a change flag are raised after the first pass that follows a start. After later passes they are raised only when a result differs from the reference. A read pulse clears both. The current sources, comparators and register transport sit outside the block.

Top module: `mpoll_top`

## Requirements
- R1: Mode encoding sets the matrix side N: 2'b00 gives N=0 (all twelve inputs standard), 2'b01 gives N=4, 2'b10 gives N=5 and 2'b11 gives N=6. Sink input s (0..5) and source input 6+s belong to the matrix when s < N. All other inputs are standard.
- R2: A pass first visits every matrix combination with the sink index as the outer loop and the source index as the inner loop, driving en_o bits r and 6+c together. It then visits each standard input in ascending index, driving en_o bit k alone. Passes repeat back to back while trigger_i stays high.
- R3: A matrix slot keeps its enables high for act_mtx_i+1 cycles and then for one strobe cycle. A standard slot does the same with act_std_i. strobe_o is high for exactly the last cycle of each slot.
- R4: cmp_i is captured at the end of each strobe cycle. Combination (r,c) lands in mtx_stat_o bit r*6+c and standard input k in std_stat_o bit k. Positions that were not polled in the pass read 0.
- R5: mtx_stat_o and std_stat_o change only at the clock edge that closes the final strobe of a pass, and they then show the whole pass.
- R6: After the first complete pass following a rising edge of trigger_i, int_n_o goes low and ssc_o goes high, whatever the results.
- R7: After any later pass, int_n_o and ssc_o are raised only if at least one status bit differs from the previous pass.
- R8: A one-cycle stat_rd_i pulse clears ssc_o and releases int_n_o high on the next cycle. If the read coincides with a pass end that raises them, the raise wins.
- R9: With trigger_i low, en_o is all zero and strobe_o is low from the next cycle on. The next rising edge of trigger_i starts a fresh pass from the first slot.
- R10: mode_i is captured at the rising edge of trigger_i. Changes while polling are ignored until the trigger is dropped and raised again.
- R11: After reset, en_o=0, strobe_o=0, int_n_o=1, ssc_o=0 and both status outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Matrix mode selector |
| trigger_i | input | 1 | Polling runs while high; a rising edge starts it |
| act_std_i | input | 4 | Active time of standard slots, minus one |
| act_mtx_i | input | 4 | Active time of matrix slots, minus one |
| stat_rd_i | input | 1 | Interrupt-status read pulse |
| cmp_i | input | 1 | Comparator result of the current slot |
| en_o | output | 12 | Per-input enable |
| strobe_o | output | 1 | Sample cycle of the current slot |
| mtx_stat_o | output | 36 | Combination results, bit r*6+c |
| std_stat_o | output | 12 | Standard input results, bit k |
| int_n_o | output | 1 | Active-low interrupt |
| ssc_o | output | 1 | Status-change flag |

## Verification
The hardest case to reach is a later pass that must stay silent, followed by one that must raise the interrupt for a single changed bit. The bench clears the first-pass interrupt with a read. It then holds its switch model steady for a full pass and checks that int_n_o stays high at the exact pass-end cycle. Next it flips one standard switch after that pass has begun and expects the interrupt one pass length later, with only that bit changed. Mode changes in mid-poll and a read that lands on the very cycle of a pass end are driven at cycle offsets computed from the programmed active times.

// File: rtl/mpoll_pkg.sv
package mpoll_pkg;

  typedef enum logic [1:0] {PH_IDLE, PH_MTX, PH_STD} phase_t;

  // Matrix side for a mode: 0 for all-standard, otherwise side-3+mode.
  function automatic int msize(input logic [1:0] m, input int side);
    return (m == 2'b00) ? 0 : side - 3 + int'(m);
  endfunction

  function automatic logic is_std(input logic [1:0] m, input int k, input int side);
    int n;
    n = msize(m, side);
    if (k < side) return (k >= n);
    return ((k - side) >= n);
  endfunction

  // First standard input with index >= start, or 2*side when none is left.
  function automatic int next_std(input logic [1:0] m, input int start, input int side);
    int res;
    res = 2 * side;
    for (int k = 2 * side - 1; k >= 0; k--) begin
      if (k >= start && is_std(m, k, side)) res = k;
    end
    return res;
  endfunction

endpackage

// File: rtl/mpoll_timer.sv
module mpoll_timer #(
  parameter int ACT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [ACT_W-1:0] limit,
  output logic             strobe
);
  localparam int CW = ACT_W + 1;

  logic [CW-1:0] cnt;

  assign strobe = run && (cnt == ({1'b0, limit} + CW'(1)));

  always_ff @(posedge clk) begin
    if (rst || !run || strobe) cnt <= '0;
    else                       cnt <= cnt + CW'(1);
  end

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);

endmodule

// File: rtl/mpoll_sched.sv
module mpoll_sched
  import mpoll_pkg::*;
#(
  parameter int SIDE  = 6,
  parameter int ACT_W = 4,
  localparam int NIN  = 2 * SIDE,
  localparam int IW   = $clog2(SIDE),
  localparam int KW   = $clog2(NIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trigger_i,
  input  logic [1:0]       mode_i,
  input  logic [ACT_W-1:0] act_std_i,
  input  logic [ACT_W-1:0] act_mtx_i,
  output logic [NIN-1:0]   en_o,
  output logic             strobe_o,
  output logic             start_o,
  output logic             slot_mtx_o,
  output logic [IW-1:0]    row_o,
  output logic [IW-1:0]    col_o,
  output logic [KW-1:0]    k_o,
  output logic             pass_end_o
);
  phase_t        phase;
  logic          trig_q;
  logic [1:0]    mode_q;
  logic [IW-1:0] r, c;
  logic [KW-1:0] k;
  int            n, nk_after, first_std;
  logic          last_mtx, run;
  logic [ACT_W-1:0] limit;

  assign start_o   = trigger_i && !trig_q;
  assign n         = msize(mode_q, SIDE);
  assign nk_after  = next_std(mode_q, int'(k) + 1, SIDE);
  assign first_std = next_std(mode_q, 0, SIDE);
  assign last_mtx  = (int'(r) == n - 1) && (int'(c) == n - 1);
  assign run       = (phase != PH_IDLE);
  assign limit     = (phase == PH_MTX) ? act_mtx_i : act_std_i;

  mpoll_timer #(.ACT_W(ACT_W)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .limit  (limit),
    .strobe (strobe_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q <= 1'b0;
      mode_q <= 2'b00;
      phase  <= PH_IDLE;
      r      <= '0;
      c      <= '0;
      k      <= '0;
    end else begin
      trig_q <= trigger_i;
      if (!trigger_i) begin
        phase <= PH_IDLE;
      end else if (start_o) begin
        mode_q <= mode_i;
        r      <= '0;
        c      <= '0;
        k      <= KW'(next_std(mode_i, 0, SIDE));
        phase  <= (msize(mode_i, SIDE) > 0) ? PH_MTX : PH_STD;
      end else if (strobe_o) begin
        unique case (phase)
          PH_MTX: begin
            if (last_mtx) begin
              r <= '0;
              c <= '0;
              if (first_std < NIN) begin
                phase <= PH_STD;
                k     <= KW'(first_std);
              end
            end else if (int'(c) == n - 1) begin
              c <= '0;
              r <= r + IW'(1);
            end else begin
              c <= c + IW'(1);
            end
          end
          PH_STD: begin
            if (nk_after < NIN) begin
              k <= KW'(nk_after);
            end else if (n > 0) begin
              phase <= PH_MTX;
              r     <= '0;
              c     <= '0;
            end else begin
              k <= KW'(first_std);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    en_o = '0;
    if (phase == PH_MTX) begin
      en_o[int'(r)]        = 1'b1;
      en_o[SIDE + int'(c)] = 1'b1;
    end else if (phase == PH_STD) begin
      en_o[int'(k)] = 1'b1;
    end
  end

  assign slot_mtx_o = (phase == PH_MTX);
  assign row_o      = r;
  assign col_o      = c;
  assign k_o        = k;
  assign pass_end_o = strobe_o && trigger_i &&
                      (((phase == PH_MTX) && last_mtx && (first_std >= NIN)) ||
                       ((phase == PH_STD) && (nk_after >= NIN)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !trigger_i |=> (en_o == '0) && !strobe_o);

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (trig_q && trigger_i) |=> $stable(mode_q));

  // R2
  mtx_first_chk: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_MTX && $past(phase) == PH_STD) |-> $past(pass_end_o));

endmodule

// File: rtl/mpoll_store.sv
module mpoll_store #(
  parameter int SIDE  = 6,
  localparam int NIN  = 2 * SIDE,
  localparam int NCMB = SIDE * SIDE,
  localparam int IW   = $clog2(SIDE),
  localparam int KW   = $clog2(NIN + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            sample,
  input  logic            slot_mtx,
  input  logic [IW-1:0]   row,
  input  logic [IW-1:0]   col,
  input  logic [KW-1:0]   k,
  input  logic            cmp,
  input  logic            pass_end,
  input  logic            stat_rd,
  output logic [NCMB-1:0] mtx_stat,
  output logic [NIN-1:0]  std_stat,
  output logic            ssc
);
  logic [NCMB-1:0] mtx_sh, mtx_nx;
  logic [NIN-1:0]  std_sh, std_nx;
  logic            first;
  logic            differs;

  always_comb begin
    mtx_nx = mtx_sh;
    std_nx = std_sh;
    if (sample) begin
      if (slot_mtx) mtx_nx[int'(row) * SIDE + int'(col)] = cmp;
      else          std_nx[int'(k)] = cmp;
    end
  end

  assign differs = (mtx_nx != mtx_stat) || (std_nx != std_stat);

  always_ff @(posedge clk) begin
    if (rst) begin
      mtx_sh   <= '0;
      std_sh   <= '0;
      mtx_stat <= '0;
      std_stat <= '0;
      first    <= 1'b0;
      ssc      <= 1'b0;
    end else begin
      if (start) begin
        first  <= 1'b1;
        mtx_sh <= '0;
        std_sh <= '0;
      end else if (pass_end) begin
        mtx_stat <= mtx_nx;
        std_stat <= std_nx;
        mtx_sh   <= '0;
        std_sh   <= '0;
        first    <= 1'b0;
      end else if (sample) begin
        mtx_sh <= mtx_nx;
        std_sh <= std_nx;
      end
      if (pass_end && (first || differs)) ssc <= 1'b1;
      else if (stat_rd)                   ssc <= 1'b0;
    end
  end

  // R8
  clear_by_read_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ssc) |-> $past(stat_rd));

  // R6
  raise_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ssc) |-> $past(pass_end));

  // R8
  read_release_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !pass_end) |=> !ssc);

  // R5
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !pass_end |=> ($stable(mtx_stat) && $stable(std_stat)));

endmodule

// File: rtl/mpoll_top.sv
module mpoll_top #(
  parameter int SIDE  = 6,
  parameter int ACT_W = 4,
  localparam int NIN  = 2 * SIDE,
  localparam int NCMB = SIDE * SIDE
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic             trigger_i,
  input  logic [ACT_W-1:0] act_std_i,
  input  logic [ACT_W-1:0] act_mtx_i,
  input  logic             stat_rd_i,
  input  logic             cmp_i,
  output logic [NIN-1:0]   en_o,
  output logic             strobe_o,
  output logic [NCMB-1:0]  mtx_stat_o,
  output logic [NIN-1:0]   std_stat_o,
  output logic             int_n_o,
  output logic             ssc_o
);
  localparam int IW = $clog2(SIDE);
  localparam int KW = $clog2(NIN + 1);

  logic          start, slot_mtx, pass_end;
  logic [IW-1:0] row, col;
  logic [KW-1:0] k;

  mpoll_sched #(.SIDE(SIDE), .ACT_W(ACT_W)) u_sched (
    .clk        (clk),
    .rst        (rst),
    .trigger_i  (trigger_i),
    .mode_i     (mode_i),
    .act_std_i  (act_std_i),
    .act_mtx_i  (act_mtx_i),
    .en_o       (en_o),
    .strobe_o   (strobe_o),
    .start_o    (start),
    .slot_mtx_o (slot_mtx),
    .row_o      (row),
    .col_o      (col),
    .k_o        (k),
    .pass_end_o (pass_end)
  );

  mpoll_store #(.SIDE(SIDE)) u_store (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .sample   (strobe_o && trigger_i),
    .slot_mtx (slot_mtx),
    .row      (row),
    .col      (col),
    .k        (k),
    .cmp      (cmp_i),
    .pass_end (pass_end),
    .stat_rd  (stat_rd_i),
    .mtx_stat (mtx_stat_o),
    .std_stat (std_stat_o),
    .ssc      (ssc_o)
  );

  assign int_n_o = ~ssc_o;

  // R4
  strobe_has_enable_chk: assert property (@(posedge clk) disable iff (rst)
    strobe_o |-> ($countones(en_o) == 1 || $countones(en_o) == 2));

endmodule

// File: tb/tb_mpoll_top.sv
module tb_mpoll_top;
  localparam int CLKP = 4;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  am;
    logic [3:0]  as;
    logic [35:0] msw;
    logic [11:0] ssw;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{2'd3, 4'd2, 4'd1, 36'h9_A5C3_0F18, 12'h0F0},
    '{2'd2, 4'd0, 4'd3, 36'h5_5AA5_33C1, 12'hA5A},
    '{2'd1, 4'd3, 4'd0, 36'hF_0F0F_1234, 12'hC3C},
    '{2'd0, 4'd1, 4'd2, 36'h0_0000_0000, 12'h6B9}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode_i = 2'b00;
  logic        trigger_i = 1'b0;
  logic [3:0]  act_std_i = '0;
  logic [3:0]  act_mtx_i = '0;
  logic        stat_rd_i = 1'b0;
  logic        cmp_i;
  logic [11:0] en_o;
  logic        strobe_o;
  logic [35:0] mtx_stat_o;
  logic [11:0] std_stat_o;
  logic        int_n_o;
  logic        ssc_o;

  logic [35:0] sw_m = '0;
  logic [11:0] sw_s = '0;
  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic [11:0] log_en [64];
  int log_n;
  int first_strobe;
  int rr, cc;

  mpoll_top dut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .trigger_i(trigger_i),
    .act_std_i(act_std_i), .act_mtx_i(act_mtx_i), .stat_rd_i(stat_rd_i),
    .cmp_i(cmp_i), .en_o(en_o), .strobe_o(strobe_o), .mtx_stat_o(mtx_stat_o),
    .std_stat_o(std_stat_o), .int_n_o(int_n_o), .ssc_o(ssc_o)
  );

  always #(CLKP/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Switch model: a pair reads the matrix switch, a single input its own switch.
  always_comb begin
    rr = -1;
    cc = -1;
    cmp_i = 1'b0;
    for (int i = 0; i < 6; i++) begin
      if (en_o[i])     rr = i;
      if (en_o[6 + i]) cc = i;
    end
    if (rr >= 0 && cc >= 0) cmp_i = sw_m[rr * 6 + cc];
    else if (rr >= 0)       cmp_i = sw_s[rr];
    else if (cc >= 0)       cmp_i = sw_s[6 + cc];
  end

  function automatic int side_n(input logic [1:0] m);
    return (m == 2'b00) ? 0 : int'(m) + 3;
  endfunction

  function automatic logic std_in(input logic [1:0] m, input int k);
    return (k < 6) ? (k >= side_n(m)) : ((k - 6) >= side_n(m));
  endfunction

  function automatic int pass_len(input logic [1:0] m, input int am, input int as);
    int t;
    t = side_n(m) * side_n(m) * (am + 2);
    for (int k = 0; k < 12; k++) if (std_in(m, k)) t += as + 2;
    return t;
  endfunction

  function automatic logic [35:0] exp_m(input logic [1:0] m, input logic [35:0] sw);
    logic [35:0] v;
    v = '0;
    for (int r = 0; r < side_n(m); r++)
      for (int c = 0; c < side_n(m); c++) v[r * 6 + c] = sw[r * 6 + c];
    return v;
  endfunction

  function automatic logic [11:0] exp_s(input logic [1:0] m, input logic [11:0] sw);
    logic [11:0] v;
    v = '0;
    for (int k = 0; k < 12; k++) if (std_in(m, k)) v[k] = sw[k];
    return v;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // Checks the logged strobe enables against the expected slot order.
  task automatic chk_order(input logic [1:0] m, input int passes, input string req);
    int idx;
    logic ok;
    logic [11:0] e;
    ok = 1'b1;
    idx = 0;
    for (int p = 0; p < passes; p++) begin
      for (int r = 0; r < side_n(m); r++)
        for (int c = 0; c < side_n(m); c++) begin
          e = '0; e[r] = 1'b1; e[6 + c] = 1'b1;
          if (idx >= log_n || log_en[idx] != e) ok = 1'b0;
          idx++;
        end
      for (int k = 0; k < 12; k++)
        if (std_in(m, k)) begin
          e = '0; e[k] = 1'b1;
          if (idx >= log_n || log_en[idx] != e) ok = 1'b0;
          idx++;
        end
    end
    chk(ok && idx == log_n, req, 64'(log_n), 64'(idx));
  endtask

  // Waits n negedges after trigger start, logging strobes.
  task automatic run_log(input int n);
    for (int i = 1; i <= n; i++) begin
      tick();
      if (strobe_o) begin
        if (first_strobe < 0) first_strobe = i;
        if (log_n < 64) log_en[log_n] = en_o;
        log_n++;
      end
    end
  endtask

  task automatic pulse_read();
    stat_rd_i = 1'b1;
    tick();
    stat_rd_i = 1'b0;
  endtask

  task automatic run_vec(input vec_t v);
    int t;
    trigger_i = 1'b0;
    tick(); tick();
    pulse_read();
    mode_i = v.mode; act_mtx_i = v.am; act_std_i = v.as;
    sw_m = v.msw; sw_s = v.ssw;
    t = pass_len(v.mode, int'(v.am), int'(v.as));
    log_n = 0; first_strobe = -1;
    trigger_i = 1'b1;
    run_log(t);
    chk(int_n_o == 1'b1, "R5 no interrupt before pass end", 64'(int_n_o), 64'd1);
    chk_order(v.mode, 1, "R2 slot order");
    chk(first_strobe == ((v.mode == 2'b00) ? int'(v.as) : int'(v.am)) + 2,
        "R3 first strobe offset", 64'(first_strobe),
        64'(((v.mode == 2'b00) ? int'(v.as) : int'(v.am)) + 2));
    tick();
    chk(int_n_o == 1'b0 && ssc_o == 1'b1, "R6 first pass interrupt", {ssc_o, int_n_o}, 64'b10);
    chk(mtx_stat_o == exp_m(v.mode, v.msw), "R4 matrix status", 64'(mtx_stat_o), 64'(exp_m(v.mode, v.msw)));
    chk(std_stat_o == exp_s(v.mode, v.ssw), "R1 standard status", 64'(std_stat_o), 64'(exp_s(v.mode, v.ssw)));
    pulse_read();
    chk(int_n_o == 1'b1 && ssc_o == 1'b0, "R8 read clears", {ssc_o, int_n_o}, 64'b01);
  endtask

  initial begin
    int t;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R11
    chk(en_o == '0 && strobe_o == 1'b0, "R11 reset enables", {strobe_o, en_o}, 64'd0);
    chk(int_n_o == 1'b1 && ssc_o == 1'b0, "R11 reset interrupt", {ssc_o, int_n_o}, 64'b01);
    chk(mtx_stat_o == '0 && std_stat_o == '0, "R11 reset status", {std_stat_o, mtx_stat_o}, 64'd0);

    for (int i = 0; i < 4; i++) run_vec(VECS[i]);

    // R7: silent pass without change, then a single flipped switch.
    trigger_i = 1'b0; tick(); tick();
    mode_i = 2'b00; act_std_i = 4'd0; act_mtx_i = 4'd0;
    sw_s = 12'h321; sw_m = '0;
    t = pass_len(2'b00, 0, 0);
    trigger_i = 1'b1;
    repeat (t + 1) tick();
    chk(int_n_o == 1'b0, "R6 interrupt after first pass", 64'(int_n_o), 64'd0);
    pulse_read();
    repeat (t - 1) tick();
    chk(int_n_o == 1'b1 && ssc_o == 1'b0, "R7 unchanged pass stays quiet", {ssc_o, int_n_o}, 64'b01);
    sw_s[3] = ~sw_s[3];
    repeat (t) tick();
    chk(int_n_o == 1'b0 && ssc_o == 1'b1, "R7 change raises interrupt", {ssc_o, int_n_o}, 64'b10);
    chk(std_stat_o == 12'h329, "R7 changed bit visible", 64'(std_stat_o), 64'h329);

    // R10: mode change in mid-poll is ignored.
    trigger_i = 1'b0; tick(); tick();
    pulse_read();
    log_n = 0; first_strobe = -1;
    trigger_i = 1'b1;
    run_log(5);
    mode_i = 2'b11;
    run_log(2 * t - 5);
    chk_order(2'b00, 2, "R10 mode change ignored");

    // R9: dropping the trigger stops polling.
    trigger_i = 1'b0;
    tick();
    chk(en_o == '0 && strobe_o == 1'b0, "R9 idle after trigger drop", {strobe_o, en_o}, 64'd0);
    pulse_read();

    // R10 and R8: retrigger takes the new mode; read coinciding with pass end loses.
    mode_i = 2'b01;
    t = pass_len(2'b01, 0, 0);
    log_n = 0; first_strobe = -1;
    trigger_i = 1'b1;
    run_log(t - 1);
    stat_rd_i = 1'b1;
    run_log(1);
    stat_rd_i = 1'b0;
    chk_order(2'b01, 1, "R10 new mode after retrigger");
    tick();
    chk(int_n_o == 1'b0 && ssc_o == 1'b1, "R8 raise wins over read", {ssc_o, int_n_o}, 64'b10);
    chk(std_stat_o == exp_s(2'b01, sw_s), "R1 4x4 standard members", 64'(std_stat_o), 64'(exp_s(2'b01, sw_s)));

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    fails++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule